// File: doc/BRIEF.md
# Nibble-Serial 8-Bit ALU with Flag Generation

This block performs 8-bit add, add-with-carry, subtract, subtract-with-borrow, AND, OR and XOR with a datapath only four bits wide. Each operation is split into two back-to-back passes through the same 4-bit unit. The low nibble goes first and the high nibble second. The outcome of the first pass (result nibble, raw carry and partial parity) is held in registers while the second pass runs. The final result and flags are then formed from the held values together with the second pass.

A controller pulses `start` for one cycle with the operands, an operation code and an incoming carry. About three cycles later the block answers with a one-cycle `done` pulse. It presents the 8-bit result with zero, carry, half-carry and parity flags, and holds them until the next operation completes. While an operation is in flight, further start requests are dropped.

Top module: `nsalu_top`

## Requirements
- R1: A `start` sampled high at a rising edge while idle is accepted. `done` is high for exactly one cycle, beginning right after the second rising edge that follows the accepting edge.
- R2: Code 0 (add) produces `a+b` and code 1 (add with carry) produces `a+b+carry_in`, both modulo 256. `f_carry` is the carry out of bit 7.
- R3: Code 2 (subtract) produces `a-b` and code 3 (subtract with borrow) produces `a-b-carry_in`, both modulo 256. `f_carry` is 1 exactly when a borrow occurs, meaning the true difference is negative.
- R4: For codes 0 to 3, `f_half` is the carry out of bit 3 for the add codes and the borrow out of bit 3 for the subtract codes.
- R5: Code 4 gives AND, code 5 gives OR, and codes 6 and 7 give XOR. For these codes `f_carry` is 0, and `f_half` is 1 for AND and 0 otherwise.
- R6: `f_zero` is 1 exactly when all eight result bits are 0.
- R7: `f_parity` is 1 exactly when the 8-bit result holds an even number of ones.
- R8: A `start` that arrives while an operation is in progress has no effect. The running operation finishes with its own operands, and no extra `done` follows.
- R9: `result` and all flags stay unchanged from one `done` until the edge that completes the next operation.
- R10: While `rst` is high and after its release, `result`, every flag and `done` are 0 until the first operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request to begin an operation |
| op | input | 3 | Operation code (0 add, 1 adc, 2 sub, 3 sbc, 4 and, 5 or, 6/7 xor) |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry or borrow for adc/sbc |
| result | output | 8 | Registered 8-bit result |
| f_zero | output | 1 | Result is zero |
| f_carry | output | 1 | Carry out (add) or borrow (subtract) |
| f_half | output | 1 | Carry or borrow at the nibble boundary |
| f_parity | output | 1 | Even parity of the result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start` is a clean synchronous level and that operands and code are valid on the edge where `start` is sampled. They assume nothing about the inputs after that edge, because the block captures everything it needs at acceptance. The stimulus changes inputs only on falling edges and lowers `start` after a single accepting edge, except in the busy scenario. There it deliberately holds `start` high across the busy cycles with different operands, to exercise the ignore path.

// File: rtl/nsalu_pkg.sv
package nsalu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_XR2 = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } seq_st_e;

  function automatic logic op_is_sub(input alu_op_e o);
    return (o == OP_SUB) || (o == OP_SBC);
  endfunction

  function automatic logic op_is_logic(input alu_op_e o);
    return o[2];
  endfunction
endpackage

// File: rtl/nsalu_nib.sv
module nsalu_nib
  import nsalu_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] a,
  input  logic [NIB_W-1:0] b,
  input  alu_op_e          op,
  input  logic             cin,
  output logic [NIB_W-1:0] y,
  output logic             cout
);
  logic [NIB_W-1:0] b_eff;
  logic [NIB_W:0]   sum;

  always_comb begin
    b_eff = op_is_sub(op) ? ~b : b;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{NIB_W{1'b0}}, cin};
    unique case (op)
      OP_AND:        begin y = a & b; cout = 1'b0; end
      OP_OR:         begin y = a | b; cout = 1'b0; end
      OP_XOR, OP_XR2:begin y = a ^ b; cout = 1'b0; end
      default:       begin y = sum[NIB_W-1:0]; cout = sum[NIB_W]; end
    endcase
  end
endmodule

// File: rtl/nsalu_seq.sv
module nsalu_seq
  import nsalu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic pass_lo,
  output logic pass_hi,
  output logic done
);
  seq_st_e st_q;

  assign accept  = start && (st_q == ST_IDLE);
  assign pass_lo = (st_q == ST_LO);
  assign pass_hi = (st_q == ST_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      done <= pass_hi;
      unique case (st_q)
        ST_IDLE: if (start) st_q <= ST_LO;
        ST_LO:   st_q <= ST_HI;
        ST_HI:   st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R1
  AST_HI_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
    pass_hi |=> done); // R1
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (start && st_q != ST_IDLE) |-> !accept); // R8
endmodule

// File: rtl/nsalu_flags.sv
module nsalu_flags
  import nsalu_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pass_lo,
  input  logic                 pass_hi,
  input  alu_op_e              op,
  input  logic [NIB_W-1:0]     y,
  input  logic                 cout,
  output logic                 lo_carry,
  output logic [2*NIB_W-1:0]   result,
  output logic                 f_zero,
  output logic                 f_carry,
  output logic                 f_half,
  output logic                 f_parity
);
  logic [NIB_W-1:0] lo_q;
  logic             par_q;
  logic             is_sub, is_log;

  assign is_sub   = op_is_sub(op);
  assign is_log   = op_is_logic(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q     <= '0;
      lo_carry <= 1'b0;
      par_q    <= 1'b0;
      result   <= '0;
      f_zero   <= 1'b0;
      f_carry  <= 1'b0;
      f_half   <= 1'b0;
      f_parity <= 1'b0;
    end else if (pass_lo) begin
      lo_q     <= y;
      lo_carry <= cout;
      par_q    <= ^y;
    end else if (pass_hi) begin
      result   <= {y, lo_q};
      f_zero   <= ~(|{y, lo_q});
      f_parity <= ~(par_q ^ (^y));
      f_carry  <= is_log ? 1'b0 : (cout ^ is_sub);
      f_half   <= is_log ? (op == OP_AND) : (lo_carry ^ is_sub);
    end
  end

  AST_ZERO_AGREES: assert property (@(posedge clk) disable iff (rst)
    pass_hi |=> (f_zero == (result == '0))); // R6
  AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (pass_hi && is_log) |=> !f_carry); // R5
endmodule

// File: rtl/nsalu_top.sv
module nsalu_top
  import nsalu_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int DATA_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              f_zero,
  output logic              f_carry,
  output logic              f_half,
  output logic              f_parity,
  output logic              done
);
  logic [DATA_W-1:0] a_q, b_q;
  alu_op_e           op_q;
  logic              ci_q;
  logic              accept, pass_lo, pass_hi;
  logic              lo_carry, first_cin, nib_cin, nib_cout;
  logic [NIB_W-1:0]  nib_a, nib_b, nib_y;

  nsalu_seq u_seq (
    .clk(clk), .rst(rst), .start(start),
    .accept(accept), .pass_lo(pass_lo), .pass_hi(pass_hi), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= '0;
      b_q  <= '0;
      op_q <= OP_ADD;
      ci_q <= 1'b0;
    end else if (accept) begin
      a_q  <= opa;
      b_q  <= opb;
      op_q <= alu_op_e'(op);
      ci_q <= carry_in;
    end
  end

  always_comb begin
    unique case (op_q)
      OP_ADC:  first_cin = ci_q;
      OP_SUB:  first_cin = 1'b1;
      OP_SBC:  first_cin = ~ci_q;
      default: first_cin = 1'b0;
    endcase
    nib_cin = pass_hi ? lo_carry : first_cin;
    nib_a   = pass_hi ? a_q[DATA_W-1:NIB_W] : a_q[NIB_W-1:0];
    nib_b   = pass_hi ? b_q[DATA_W-1:NIB_W] : b_q[NIB_W-1:0];
  end

  nsalu_nib #(.NIB_W(NIB_W)) u_nib (
    .a(nib_a), .b(nib_b), .op(op_q), .cin(nib_cin),
    .y(nib_y), .cout(nib_cout)
  );

  nsalu_flags #(.NIB_W(NIB_W)) u_flags (
    .clk(clk), .rst(rst), .pass_lo(pass_lo), .pass_hi(pass_hi), .op(op_q),
    .y(nib_y), .cout(nib_cout), .lo_carry(lo_carry), .result(result),
    .f_zero(f_zero), .f_carry(f_carry), .f_half(f_half), .f_parity(f_parity)
  );

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !pass_hi |=> ($stable(result) && $stable(f_carry) && $stable(f_half))); // R9
  AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (pass_lo || pass_hi) |=> ($stable(a_q) && $stable(b_q) && $stable(op_q))); // R8
endmodule

// File: tb/sim_nsalu_top.sv
module sim_nsalu_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] opa = '0, opb = '0;
  logic       carry_in = 1'b0;
  logic [7:0] result;
  logic       f_zero, f_carry, f_half, f_parity, done;
  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  nsalu_top u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .carry_in(carry_in), .result(result), .f_zero(f_zero), .f_carry(f_carry),
    .f_half(f_half), .f_parity(f_parity), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Reference model over full 8-bit width
  task automatic model(input int o, input int a, input int b, input int c,
                       output int r, output int cy, output int h);
    int s, bw;
    if (o <= 1) begin
      s  = a + b + ((o == 1) ? c : 0);
      r  = s & 255; cy = s >> 8;
      h  = ((a & 15) + (b & 15) + ((o == 1) ? c : 0)) >> 4;
    end else if (o <= 3) begin
      bw = (o == 3) ? c : 0;
      s  = a - b - bw;
      r  = s & 255; cy = (s < 0) ? 1 : 0;
      h  = (((a & 15) - (b & 15) - bw) < 0) ? 1 : 0;
    end else begin
      r  = (o == 4) ? (a & b) : (o == 5) ? (a | b) : (a ^ b);
      cy = 0; h = (o == 4) ? 1 : 0;
    end
  endtask

  // Launch at a falling edge; return at the falling edge where done is due.
  task automatic launch(input int o, input int a, input int b, input int c);
    op = 3'(o); opa = 8'(a); opb = 8'(b); carry_in = c[0];
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_outputs(input int o, input int a, input int b, input int c);
    int r, cy, h, ones;
    string rq;
    model(o, a, b, c, r, cy, h);
    ones = $countones(8'(r));
    rq = (o <= 1) ? "R2" : (o <= 3) ? "R3" : "R5";
    chk(done == 1'b1, "R1", done, 1);
    chk(result == 8'(r), rq, result, r);
    chk(f_carry == cy[0], rq, f_carry, cy);
    chk(f_half == h[0], (o <= 3) ? "R4" : "R5", f_half, h);
    chk(f_zero == (r == 0), "R6", f_zero, (r == 0));
    chk(f_parity == ((ones % 2) == 0), "R7", f_parity, ((ones % 2) == 0));
  endtask

  task automatic t_reset();
    chk(result == 8'h00, "R10", result, 0);
    chk({f_zero, f_carry, f_half, f_parity} == 4'b0, "R10",
        {f_zero, f_carry, f_half, f_parity}, 0);
    chk(done == 1'b0, "R10", done, 0);
  endtask

  task automatic t_timing();
    op = 3'd0; opa = 8'h12; opb = 8'h34; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R1", done, 0);
    @(negedge clk);
    chk(done == 1'b0, "R1", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R1", done, 1);
    chk(result == 8'h46, "R2", result, 8'h46);
    @(negedge clk);
    chk(done == 1'b0, "R1", done, 0);
  endtask

  task automatic t_sweep();
    int alist[8] = '{8'h00, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hA5, 8'hF0, 8'hFF};
    for (int o = 0; o < 8; o++)
      for (int ai = 0; ai < 8; ai++)
        for (int b = 0; b < 256; b++) begin
          int c = ((b >> 1) ^ alist[ai] ^ o) & 1;
          launch(o, alist[ai], b, c);
          check_outputs(o, alist[ai], b, c);
        end
  endtask

  task automatic t_corners();
    launch(2, 8'h00, 8'h01, 0); check_outputs(2, 8'h00, 8'h01, 0); // R3 full borrow
    launch(3, 8'h10, 8'h0F, 1); check_outputs(3, 8'h10, 8'h0F, 1); // R3 R4 zero result
    launch(1, 8'hFF, 8'h00, 1); check_outputs(1, 8'hFF, 8'h00, 1); // R2 R6 wrap to zero
    launch(0, 8'h08, 8'h08, 0); check_outputs(0, 8'h08, 8'h08, 0); // R4 half only
  endtask

  task automatic t_busy();
    op = 3'd0; opa = 8'h21; opb = 8'h11; carry_in = 1'b0; start = 1'b1;
    @(negedge clk);
    op = 3'd6; opa = 8'hFF; opb = 8'h0F; // held high while busy
    @(negedge clk);
    @(negedge clk); start = 1'b0;
    chk(done == 1'b1, "R8", done, 1);
    chk(result == 8'h32, "R8", result, 8'h32);
    @(negedge clk);
    chk(done == 1'b0, "R8", done, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", done, 0);
    chk(result == 8'h32, "R8", result, 8'h32);
  endtask

  task automatic t_hold();
    launch(5, 8'hC0, 8'h03, 0);
    opa = 8'h00; opb = 8'h00; op = 3'd4;
    repeat (3) begin
      @(negedge clk);
      chk(result == 8'hC3, "R9", result, 8'hC3);
      chk(f_half == 1'b0 && f_zero == 1'b0, "R9", {f_half, f_zero}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timing();
    t_corners();
    t_busy();
    t_hold();
    t_sweep();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end
endmodule